// File: doc/BRIEF.md
# Banked Packet Pointer Data Window

This block gives a host byte-wide, indirect access to a small paged packet buffer. The buffer holds four pages of 2048 bytes. The host sees a 16-byte register window that is split into banks. A bank select register sits at a fixed offset in every bank. In bank 2 there is a 16-bit pointer register and a four-byte data window. Every access to the data window reads or writes one byte of the packet buffer at the place the pointer names.

Two pointer bits set how the window behaves. Bit 15 picks the page. When it is set, the page comes from the receive-queue head input. When it is clear, the page comes from the packet number input. Bit 14 picks the addressing mode. In auto-increment mode, each access uses the pointer offset as it stands and then advances the offset. In fixed mode, the byte lane of the window is added to the offset and the pointer does not move.

A host access may be one, two or four bytes wide. The block splits it into byte accesses, one lane per cycle in little-endian order, and holds busy until the last lane is done. A read returns its assembled data with a one-cycle valid pulse.

Top module: `pkt_window`

## Requirements
- R1: After reset the bank select register and the pointer read as zero, and busy_o and rvalid_o are low.
- R2: Offset 14 is the bank select register. It can be written and read in every bank. Offset 15 always reads 0x33, and writes to it change nothing.
- R3: In bank 2, offset 6 holds the low byte of the pointer and offset 7 holds the high byte. A read of offset 7 returns the high byte ANDed with 0xF7, so pointer bit 11 reads as 0.
- R4: In bank 2, offsets 8 to 11 form the data window. When pointer bit 15 is 0 the accessed page is pnum_i. When bit 15 is 1 it is rxhead_i. The byte within the page is set by pointer bits 10:0.
- R5: When pointer bit 14 is 1, a data-window access uses pointer bits 10:0 unchanged. After the access, bits 10:0 increment and wrap from 0x7FF to 0x000, and bits 15:11 keep their value.
- R6: When pointer bit 14 is 0, a data-window access uses pointer bits 10:0 plus the window lane (offset modulo 4), wrapping within the page. The pointer is left unchanged.
- R7: Offsets that are not implemented in the current bank read as zero, and writes to them change no register and no buffer byte. This includes offsets 6 to 11 when the bank is not 2.
- R8: size_i encodes the access width: 0 means 1 byte, 1 means 2 bytes, and 2 or 3 means 4 bytes. An access of N bytes reaches offsets addr_i to addr_i+N-1, with lane k carried on data bits 8k+7:8k. It takes N cycles with busy_o high. A read then pulses rvalid_o for one cycle, as busy_o falls, with the assembled data.
- R9: A 4-byte write to offset 12 performs only the lanes for offsets 14 and 15. Data bits 23:16 go to the bank select register, and the access takes two busy cycles.
- R10: A request raised while busy_o is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, accepted when busy_o is low |
| we_i | input | 1 | 1 for a write, 0 for a read |
| addr_i | input | 4 | Byte offset of the first lane in the register window |
| size_i | input | 2 | Access width code (0: 1 byte, 1: 2 bytes, 2 or 3: 4 bytes) |
| wdata_i | input | 32 | Write data, lane k on bits 8k+7:8k |
| pnum_i | input | 2 | Page used when pointer bit 15 is 0 |
| rxhead_i | input | 2 | Page used when pointer bit 15 is 1 |
| busy_o | output | 1 | High while the lanes of an accepted access are being performed |
| rvalid_o | output | 1 | One-cycle pulse when read data is complete |
| rdata_o | output | 32 | Assembled read data, valid with rvalid_o |

## Verification
The assertions assume that pnum_i and rxhead_i are driven to known values whenever the data window is accessed. They also assume that request fields are only meaningful in the cycle a request is accepted. The bench changes the page inputs only between accesses, while busy_o is low. For each access it raises req_i for exactly one idle cycle and then waits for busy_o to fall before the next access. The one exception is a deliberate overlapping request, which checks that a busy block ignores new requests.

// File: rtl/pkt_window_pkg.sv
package pkt_window_pkg;
  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD3 = 2'd3} acc_size_e;

  localparam logic [3:0] OFF_BANK   = 4'd14;
  localparam logic [3:0] OFF_ID     = 4'd15;
  localparam logic [3:0] OFF_PTR_LO = 4'd6;
  localparam logic [3:0] OFF_PTR_HI = 4'd7;
  localparam logic [3:0] OFF_WSPLIT = 4'd12;
  localparam logic [7:0] BANK_DATA  = 8'd2;
  localparam logic [7:0] ID_VALUE   = 8'h33;
  localparam logic [7:0] PTR_HI_MSK = 8'hF7;
  localparam int         PTR_SRC    = 15;
  localparam int         PTR_AINC   = 14;
endpackage

// File: rtl/pkt_window_ram.sv
module pkt_window_ram #(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11,
  parameter int ADDR_W  = $clog2(PAGES) + PAGE_AW
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o
);
  localparam int WORDS = (PAGES << PAGE_AW) / 4;

  logic [7:0] lane_rd [4];

  // one byte-wide array per lane keeps each array at a quarter of the buffer
  for (genvar l = 0; l < 4; l++) begin : g_lane
    logic [7:0] mem [WORDS];
    always_ff @(posedge clk_i) begin
      if (we_i && addr_i[1:0] == 2'(l)) mem[addr_i[ADDR_W-1:2]] <= wdata_i;
    end
    assign lane_rd[l] = mem[addr_i[ADDR_W-1:2]];
  end

  assign rdata_o = lane_rd[addr_i[1:0]];
endmodule

// File: rtl/pkt_window_seq.sv
module pkt_window_seq
  import pkt_window_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [3:0]  addr_i,
  input  logic [1:0]  size_i,
  input  logic [31:0] wdata_i,
  output logic        busy_o,
  output logic        rvalid_o,
  output logic [31:0] rdata_o,
  output logic        b_en_o,
  output logic        b_we_o,
  output logic [3:0]  b_addr_o,
  output logic [7:0]  b_wdata_o,
  input  logic [7:0]  b_rdata_i
);
  logic        active_q, we_q, rvalid_q;
  logic [1:0]  lane_q, last_q;
  logic [3:0]  base_q;
  logic [31:0] wdata_q, rdata_q;
  logic        accept;
  acc_size_e   size;

  assign size   = acc_size_e'(size_i);
  assign accept = req_i && !active_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      rvalid_q <= 1'b0;
      lane_q   <= '0;
      last_q   <= '0;
      base_q   <= '0;
      wdata_q  <= '0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        we_q     <= we_i;
        base_q   <= addr_i;
        wdata_q  <= wdata_i;
        rdata_q  <= '0;
        unique case (size)
          SZ_BYTE: last_q <= 2'd0;
          SZ_HALF: last_q <= 2'd1;
          default: last_q <= 2'd3;
        endcase
        // word write to offset 12 only reaches the bank select lanes
        lane_q <= (we_i && size_i[1] && addr_i == OFF_WSPLIT) ? 2'd2 : 2'd0;
      end else if (active_q) begin
        if (!we_q) rdata_q[{lane_q, 3'b000} +: 8] <= b_rdata_i;
        if (lane_q == last_q) begin
          active_q <= 1'b0;
          rvalid_q <= !we_q;
        end else begin
          lane_q <= lane_q + 2'd1;
        end
      end
    end
  end

  assign busy_o    = active_q;
  assign rvalid_o  = rvalid_q;
  assign rdata_o   = rdata_q;
  assign b_en_o    = active_q;
  assign b_we_o    = we_q;
  assign b_addr_o  = base_q + {2'b00, lane_q};
  assign b_wdata_o = wdata_q[{lane_q, 3'b000} +: 8];
endmodule

// File: rtl/pkt_window_regs.sv
module pkt_window_regs
  import pkt_window_pkg::*;
#(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11,
  parameter int PG_W    = $clog2(PAGES),
  parameter int ADDR_W  = PG_W + PAGE_AW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              we_i,
  input  logic [3:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic [PG_W-1:0]   pnum_i,
  input  logic [PG_W-1:0]   rxhead_i,
  output logic              ram_we_o,
  output logic [ADDR_W-1:0] ram_addr_o,
  output logic [7:0]        ram_wdata_o,
  input  logic [7:0]        ram_rdata_i,
  output logic [7:0]        bank_o,
  output logic [15:0]       ptr_o
);
  logic [7:0]         bank_q;
  logic [15:0]        ptr_q;
  logic               in_data_bank, data_hit;
  logic [PAGE_AW-1:0] offs, eff_offs;
  logic [PG_W-1:0]    page;

  assign in_data_bank = (bank_q == BANK_DATA);
  assign data_hit     = in_data_bank && addr_i[3:2] == 2'b10;
  assign offs         = ptr_q[PAGE_AW-1:0];
  assign eff_offs     = ptr_q[PTR_AINC] ? offs : offs + PAGE_AW'(addr_i[1:0]);
  assign page         = ptr_q[PTR_SRC] ? rxhead_i : pnum_i;

  assign ram_addr_o  = {page, eff_offs};
  assign ram_wdata_o = wdata_i;
  assign ram_we_o    = en_i && we_i && data_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= '0;
      ptr_q  <= '0;
    end else if (en_i) begin
      if (we_i && addr_i == OFF_BANK) bank_q <= wdata_i;
      if (we_i && in_data_bank && addr_i == OFF_PTR_LO) ptr_q[7:0]  <= wdata_i;
      if (we_i && in_data_bank && addr_i == OFF_PTR_HI) ptr_q[15:8] <= wdata_i;
      if (data_hit && ptr_q[PTR_AINC]) ptr_q[PAGE_AW-1:0] <= offs + 1'b1;
    end
  end

  always_comb begin
    rdata_o = 8'h00;
    if (addr_i == OFF_BANK)                       rdata_o = bank_q;
    else if (addr_i == OFF_ID)                    rdata_o = ID_VALUE;
    else if (in_data_bank && addr_i == OFF_PTR_LO) rdata_o = ptr_q[7:0];
    else if (in_data_bank && addr_i == OFF_PTR_HI) rdata_o = ptr_q[15:8] & PTR_HI_MSK;
    else if (data_hit)                            rdata_o = ram_rdata_i;
  end

  assign bank_o = bank_q;
  assign ptr_o  = ptr_q;
endmodule

// File: rtl/pkt_window.sv
module pkt_window #(
  parameter int PAGES   = 4,
  parameter int PAGE_AW = 11,
  localparam int PG_W   = $clog2(PAGES)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_i,
  input  logic            we_i,
  input  logic [3:0]      addr_i,
  input  logic [1:0]      size_i,
  input  logic [31:0]     wdata_i,
  input  logic [PG_W-1:0] pnum_i,
  input  logic [PG_W-1:0] rxhead_i,
  output logic            busy_o,
  output logic            rvalid_o,
  output logic [31:0]     rdata_o
);
  localparam int ADDR_W = PG_W + PAGE_AW;

  logic              b_en, b_we;
  logic [3:0]        b_addr;
  logic [7:0]        b_wdata, b_rdata;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_addr;
  logic [7:0]        ram_wdata, ram_rdata;
  logic [7:0]        bank_w;
  logic [15:0]       ptr_w;

  pkt_window_seq u_seq (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .size_i, .wdata_i,
    .busy_o, .rvalid_o, .rdata_o,
    .b_en_o(b_en), .b_we_o(b_we), .b_addr_o(b_addr),
    .b_wdata_o(b_wdata), .b_rdata_i(b_rdata)
  );

  pkt_window_regs #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_regs (
    .clk_i, .rst_ni,
    .en_i(b_en), .we_i(b_we), .addr_i(b_addr), .wdata_i(b_wdata), .rdata_o(b_rdata),
    .pnum_i, .rxhead_i,
    .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata),
    .ram_rdata_i(ram_rdata), .bank_o(bank_w), .ptr_o(ptr_w)
  );

  pkt_window_ram #(.PAGES(PAGES), .PAGE_AW(PAGE_AW)) u_ram (
    .clk_i, .we_i(ram_we), .addr_i(ram_addr), .wdata_i(ram_wdata), .rdata_o(ram_rdata)
  );
endmodule

// File: rtl/pkt_window_chk.sv
module pkt_window_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        req_i,
  input logic        busy_o,
  input logic        rvalid_o,
  input logic        b_en,
  input logic [3:0]  b_addr,
  input logic [7:0]  bank_w,
  input logic [15:0] ptr_w
);
  logic data_acc;
  assign data_acc = b_en && bank_w == 8'd2 && b_addr[3:2] == 2'b10;

  p_accept_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o |=> busy_o);
  p_rvalid_at_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> !busy_o && $past(busy_o));
  p_rvalid_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o);
  p_ptr_fixed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && !ptr_w[14] |=> $stable(ptr_w));
  p_ptr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_acc && ptr_w[14] |=> ptr_w[10:0] == $past(ptr_w[10:0]) + 11'd1
                              && ptr_w[15:11] == $past(ptr_w[15:11]));
  p_bank_only_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(b_en && b_addr == 4'd14) |=> $stable(bank_w));
  p_idle_no_lane_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !b_en);
endmodule

bind pkt_window pkt_window_chk u_chk (
  .clk_i, .rst_ni, .req_i, .busy_o, .rvalid_o,
  .b_en(b_en), .b_addr(b_addr), .bank_w(bank_w), .ptr_w(ptr_w)
);

// File: tb/pkt_window_tb_top.sv
`timescale 1ns/1ps
module pkt_window_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [3:0]  addr_i = '0;
  logic [1:0]  size_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  pnum_i = '0, rxhead_i = '0;
  logic        busy_o, rvalid_o;
  logic [31:0] rdata_o;

  int n_chk = 0, n_bad = 0;

  pkt_window dut_i (.*);

  always #2.5 clk_i = ~clk_i;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit we, input logic [3:0] a, input logic [1:0] sz,
                     input logic [31:0] wd, output logic [31:0] rd, output int cyc,
                     output logic rv);
    @(negedge clk_i);
    req_i = 1'b1; we_i = we; addr_i = a; size_i = sz; wdata_i = wd;
    @(negedge clk_i);
    req_i = 1'b0;
    cyc = 0;
    while (busy_o) begin
      cyc++;
      @(negedge clk_i);
    end
    rd = rdata_o;
    rv = rvalid_o;
  endtask

  task automatic wr8(input logic [3:0] a, input logic [7:0] d);
    logic [31:0] r; int c; logic v;
    acc(1'b1, a, 2'd0, {24'h0, d}, r, c, v);
  endtask

  task automatic rd8(input logic [3:0] a, output logic [7:0] d);
    logic [31:0] r; int c; logic v;
    acc(1'b0, a, 2'd0, 32'h0, r, c, v);
    d = r[7:0];
  endtask

  task automatic set_ptr(input logic [15:0] p);
    wr8(4'd6, p[7:0]);
    wr8(4'd7, p[15:8]);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 busy", {31'h0, busy_o}, 32'h0);
    chk("R1 rvalid", {31'h0, rvalid_o}, 32'h0);
    rd8(4'd14, d); chk("R1 bank", {24'h0, d}, 32'h0);
    wr8(4'd14, 8'd2);
    rd8(4'd6, d); chk("R1 ptr lo", {24'h0, d}, 32'h0);
    rd8(4'd7, d); chk("R1 ptr hi", {24'h0, d}, 32'h0);
  endtask

  task automatic t_bank;
    logic [7:0] d;
    wr8(4'd14, 8'd3);
    rd8(4'd14, d); chk("R2 bank3", {24'h0, d}, 32'h3);
    rd8(4'd15, d); chk("R2 id", {24'h0, d}, 32'h33);
    wr8(4'd15, 8'h55);
    rd8(4'd15, d); chk("R2 id after write", {24'h0, d}, 32'h33);
    wr8(4'd14, 8'd1);
    rd8(4'd14, d); chk("R2 bank1", {24'h0, d}, 32'h1);
    wr8(4'd14, 8'd2);
  endtask

  task automatic t_ptr_mask;
    logic [7:0] d;
    set_ptr(16'hFF34);
    rd8(4'd6, d); chk("R3 ptr lo", {24'h0, d}, 32'h34);
    rd8(4'd7, d); chk("R3 ptr hi mask", {24'h0, d}, 32'hF7);
  endtask

  task automatic t_autoinc;
    logic [7:0] d;
    pnum_i = 2'd1;
    set_ptr(16'h47FE);
    wr8(4'd8, 8'hA1);
    wr8(4'd11, 8'hA2);
    wr8(4'd9, 8'hA3);
    rd8(4'd6, d); chk("R5 ptr lo wrap", {24'h0, d}, 32'h01);
    rd8(4'd7, d); chk("R5 ptr hi kept", {24'h0, d}, 32'h40);
    set_ptr(16'h07FE);
    rd8(4'd8, d); chk("R5 byte 7fe", {24'h0, d}, 32'hA1);
    rd8(4'd9, d); chk("R5 byte 7ff", {24'h0, d}, 32'hA2);
    set_ptr(16'h0000);
    rd8(4'd8, d); chk("R5 byte 000", {24'h0, d}, 32'hA3);
  endtask

  task automatic t_page_sel;
    logic [7:0] d;
    pnum_i = 2'd2;
    set_ptr(16'h0000);
    wr8(4'd8, 8'h5C);
    pnum_i = 2'd1;
    rd8(4'd8, d); chk("R4 pnum page1", {24'h0, d}, 32'hA3);
    rxhead_i = 2'd2;
    set_ptr(16'h8000);
    rd8(4'd8, d); chk("R4 rxhead page2", {24'h0, d}, 32'h5C);
    rxhead_i = 2'd1; pnum_i = 2'd2;
    rd8(4'd8, d); chk("R4 rxhead page1", {24'h0, d}, 32'hA3);
  endtask

  task automatic t_lane_offs;
    logic [7:0] d; logic [31:0] r; int c; logic v;
    pnum_i = 2'd3;
    set_ptr(16'h0010);
    acc(1'b1, 4'd8, 2'd2, 32'h44332211, r, c, v);
    rd8(4'd6, d); chk("R6 ptr unchanged lo", {24'h0, d}, 32'h10);
    rd8(4'd7, d); chk("R6 ptr unchanged hi", {24'h0, d}, 32'h00);
    acc(1'b0, 4'd8, 2'd2, 32'h0, r, c, v);
    chk("R6 word read", r, 32'h44332211);
    set_ptr(16'h0011);
    rd8(4'd8, d); chk("R6 lane0", {24'h0, d}, 32'h22);
    rd8(4'd10, d); chk("R6 lane2", {24'h0, d}, 32'h44);
    set_ptr(16'h07FF);
    wr8(4'd9, 8'h9E);
    rd8(4'd6, d); chk("R6 ptr held after wrap", {24'h0, d}, 32'hFF);
    set_ptr(16'h0000);
    rd8(4'd8, d); chk("R6 wrap in page", {24'h0, d}, 32'h9E);
  endtask

  task automatic t_unimpl;
    logic [7:0] d;
    wr8(4'd14, 8'd0);
    wr8(4'd8, 8'hEE);
    wr8(4'd6, 8'h12);
    rd8(4'd8, d); chk("R7 bank0 data reads 0", {24'h0, d}, 32'h0);
    rd8(4'd6, d); chk("R7 bank0 ptr reads 0", {24'h0, d}, 32'h0);
    wr8(4'd14, 8'd2);
    rd8(4'd6, d); chk("R7 ptr untouched", {24'h0, d}, 32'h00);
    rd8(4'd8, d); chk("R7 page byte untouched", {24'h0, d}, 32'h9E);
    wr8(4'd3, 8'h5A);
    rd8(4'd3, d); chk("R7 offset3 reads 0", {24'h0, d}, 32'h0);
  endtask

  task automatic t_split;
    logic [31:0] r; int c; logic v;
    acc(1'b0, 4'd14, 2'd1, 32'h0, r, c, v);
    chk("R8 half data", r, 32'h00003302);
    chk("R8 half cycles", c, 2);
    chk("R8 half rvalid", {31'h0, v}, 32'h1);
    acc(1'b0, 4'd12, 2'd2, 32'h0, r, c, v);
    chk("R8 word data", r, 32'h33020000);
    chk("R8 word cycles", c, 4);
    acc(1'b0, 4'd14, 2'd0, 32'h0, r, c, v);
    chk("R8 byte cycles", c, 1);
  endtask

  task automatic t_word_c;
    logic [7:0] d; logic [31:0] r; int c; logic v;
    acc(1'b1, 4'd12, 2'd2, 32'h7701ABCD, r, c, v);
    chk("R9 two lanes", c, 2);
    chk("R9 write no rvalid", {31'h0, v}, 32'h0);
    rd8(4'd14, d); chk("R9 bank", {24'h0, d}, 32'h01);
    rd8(4'd15, d); chk("R9 id kept", {24'h0, d}, 32'h33);
    wr8(4'd14, 8'd2);
  endtask

  task automatic t_busy_req;
    logic [7:0] d; int c;
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = 4'd12; size_i = 2'd2; wdata_i = '0;
    @(negedge clk_i);
    we_i = 1'b1; addr_i = 4'd14; size_i = 2'd0; wdata_i = 32'h0;
    @(negedge clk_i);
    @(negedge clk_i);
    req_i = 1'b0;
    c = 0;
    while (busy_o) begin c++; @(negedge clk_i); end
    chk("R10 read data", rdata_o, 32'h33020000);
    rd8(4'd14, d); chk("R10 bank unchanged", {24'h0, d}, 32'h02);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_bank();
    t_ptr_mask();
    t_autoinc();
    t_page_sel();
    t_lane_offs();
    t_unimpl();
    t_split();
    t_word_c();
    t_busy_req();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog R8 act=hang exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule